// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker turns a 32-bit virtual address into a physical address by reading a two-level descriptor tree from memory. A request carries the virtual address and the base of the first-level table. The walker reads one first-level descriptor. That descriptor either maps a 1MB section at once, points to a second-level table, or marks a fault. When it points to a table, the walker makes a second read. The second-level descriptor maps a 4KB page or marks a fault.

The virtual address is split into three fields. The top 12 bits index a 4096-entry first-level table. The next 8 bits index a 256-entry second-level table. The low 12 bits are the page offset and pass through unchanged. Descriptors are 4 bytes wide. The first-level table base is 16KB aligned and a second-level table base is 1KB aligned. The walker handles one request at a time. Memory reads use a plain word-read port with a variable response latency.

Top module: `ptw_walker`

## Requirements
- R1: After reset, req_ready_o is 1, done_o is 0 and mem_rd_o is 0.
- R2: The first read goes to address {ttb[31:14], va[31:20], 2'b00}.
- R3: A first-level descriptor whose bits [1:0] are 2 or 3 is a section. The walk ends after that single read with fault_o = 0 and pa_o = {desc[31:20], va[19:0]}.
- R4: A first-level descriptor whose bits [1:0] equal 1 points to a table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R5: A second-level descriptor whose bits [1:0] are 2 or 3 is a small page. The result is fault_o = 0 and pa_o = {desc[31:12], va[11:0]}.
- R6: A first-level descriptor whose bits [1:0] equal 0 ends the walk with fault_o = 1. No second read is made.
- R7: A second-level descriptor whose bits [1:0] are 0 or 1 ends the walk with fault_o = 1.
- R8: done_o is a one-cycle pulse. It arrives in the cycle after the final read's mem_rvalid_i is sampled. req_ready_o is 0 while a walk is in progress.
- R9: mem_rd_o stays high with mem_addr_o stable from the read's first cycle until mem_rvalid_i is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to accept a request |
| req_va_i | input | 32 | Virtual address to translate |
| req_ttb_i | input | 32 | First-level table base (bits 31:14 used) |
| mem_rd_o | output | 1 | Descriptor read request, held until the response |
| mem_addr_o | output | 32 | Descriptor byte address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor read data |
| done_o | output | 1 | Walk complete, one-cycle pulse |
| fault_o | output | 1 | Translation fault for the finished walk |
| pa_o | output | 32 | Physical address for the finished walk |

## Verification
A request accepted at one edge puts the first read on the port in the next cycle. Every read then holds until the bench's memory model returns data after 0 to 2 extra cycles. The bench samples done_o, fault_o and pa_o at the falling edge right after the final response edge, and checks that done_o has dropped one cycle later. The bench records each read address and the read count in the memory model and compares them with values it computes from the stimulus. The sweep covers every pairing of first-level and second-level descriptor type across several address patterns and latencies.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2} walk_st_e;
  typedef enum logic [1:0] {DK_FAULT, DK_TABLE, DK_LEAF} desc_kind_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned L1_IDX_W = 12,
  parameter int unsigned L2_IDX_W = 8,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned TTB_LSB = L1_IDX_W + 2,
  localparam int unsigned L2B_LSB = L2_IDX_W + 2
) (
  input  logic [VA_W-1:0]         va_i,
  input  logic [VA_W-1:0]         ttb_i,
  input  logic [VA_W-L2B_LSB-1:0] l2_base_i,
  input  logic                    sel_l2_i,
  output logic [VA_W-1:0]         addr_o
);
  always_comb begin
    if (sel_l2_i) addr_o = {l2_base_i, va_i[OFF_W +: L2_IDX_W], 2'b00};
    else          addr_o = {ttb_i[VA_W-1:TTB_LSB], va_i[VA_W-1 -: L1_IDX_W], 2'b00};
  end
endmodule

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode import ptw_pkg::*; #(
  parameter int unsigned VA_W     = 32,
  parameter int unsigned L2_IDX_W = 8,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned SEC_W   = L2_IDX_W + OFF_W
) (
  input  logic [VA_W-1:0] desc_i,
  input  logic [VA_W-1:0] va_i,
  input  logic            is_l2_i,
  output desc_kind_e      kind_o,
  output logic [VA_W-1:0] pa_o
);
  always_comb begin
    unique case (desc_i[1:0])
      2'b00:   kind_o = DK_FAULT;
      2'b01:   kind_o = is_l2_i ? DK_FAULT : DK_TABLE;
      default: kind_o = DK_LEAF;
    endcase
    if (is_l2_i) pa_o = {desc_i[VA_W-1:OFF_W], va_i[OFF_W-1:0]};
    else         pa_o = {desc_i[VA_W-1:SEC_W], va_i[SEC_W-1:0]};
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker import ptw_pkg::*; #(
  parameter int unsigned L1_IDX_W = 12,
  parameter int unsigned L2_IDX_W = 8,
  parameter int unsigned OFF_W    = 12,
  localparam int unsigned VA_W    = L1_IDX_W + L2_IDX_W + OFF_W,
  localparam int unsigned L2B_LSB = L2_IDX_W + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [VA_W-1:0] req_va_i,
  input  logic [VA_W-1:0] req_ttb_i,
  output logic            mem_rd_o,
  output logic [VA_W-1:0] mem_addr_o,
  input  logic            mem_rvalid_i,
  input  logic [VA_W-1:0] mem_rdata_i,
  output logic            done_o,
  output logic            fault_o,
  output logic [VA_W-1:0] pa_o
);
  walk_st_e               st_q;
  logic [VA_W-1:0]         va_q, ttb_q, pa_q, leaf_pa;
  logic [VA_W-L2B_LSB-1:0] l2b_q;
  logic                    done_q, fault_q;
  desc_kind_e              kind;

  ptw_addr_gen #(.VA_W(VA_W), .L1_IDX_W(L1_IDX_W), .L2_IDX_W(L2_IDX_W), .OFF_W(OFF_W)) u_addr (
    .va_i(va_q), .ttb_i(ttb_q), .l2_base_i(l2b_q), .sel_l2_i(st_q == ST_L2), .addr_o(mem_addr_o));

  ptw_desc_decode #(.VA_W(VA_W), .L2_IDX_W(L2_IDX_W), .OFF_W(OFF_W)) u_dec (
    .desc_i(mem_rdata_i), .va_i(va_q), .is_l2_i(st_q == ST_L2), .kind_o(kind), .pa_o(leaf_pa));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      va_q    <= '0;
      ttb_q   <= '0;
      l2b_q   <= '0;
      pa_q    <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q  <= req_va_i;
          ttb_q <= req_ttb_i;
          st_q  <= ST_L1;
        end
        default: if (mem_rvalid_i) begin
          unique case (kind)
            DK_TABLE: begin
              l2b_q <= mem_rdata_i[VA_W-1:L2B_LSB];
              st_q  <= ST_L2;
            end
            DK_LEAF: begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              pa_q    <= leaf_pa;
              st_q    <= ST_IDLE;
            end
            default: begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              pa_q    <= '0;
              st_q    <= ST_IDLE;
            end
          endcase
        end
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign mem_rd_o    = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign fault_o     = fault_q;
  assign pa_o        = pa_q;

  a_r1_idle_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !mem_rd_o);
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_after_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && mem_rvalid_i && mem_rdata_i[1] |=> done_o && req_ready_o);
  a_r9_hold_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_addr_o));
  a_r6_l1_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_L1) && mem_rvalid_i && (mem_rdata_i[1:0] == 2'b00) |=> done_o && fault_o && !mem_rd_o);
  a_r4_table_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_L1) && mem_rvalid_i && (mem_rdata_i[1:0] == 2'b01) |=> mem_rd_o && !done_o);
endmodule

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0, req_ttb = '0;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        req_ready, mem_rd, done, fault;
  logic [31:0] mem_addr, pa;

  int n_chk = 0, n_bad = 0;
  int lat = 0, n_reads = 0;
  logic [31:0] l1d, l2d, addr1, addr2;
  logic done_after_rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_va_i(req_va), .req_ttb_i(req_ttb), .mem_rd_o(mem_rd), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .done_o(done), .fault_o(fault), .pa_o(pa));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: latency lat extra cycles, rvalid for one cycle
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_rd) begin
        logic [31:0] a;
        a = mem_addr;
        chk("R8 ready low in walk", {31'b0, req_ready}, 32'd0);
        n_reads++;
        if (n_reads == 1) addr1 = a; else addr2 = a;
        for (int i = 0; i < lat; i++) begin
          @(negedge clk);
          chk("R9 read held", {31'b0, mem_rd}, 32'd1);
          chk("R9 addr stable", mem_addr, a);
        end
        mem_rvalid = 1'b1;
        mem_rdata  = (n_reads == 1) ? l1d : l2d;
        @(negedge clk);
        mem_rvalid = 1'b0;
        done_after_rv = done;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] ttb,
                      input logic [31:0] d1, input logic [31:0] d2, input int lt);
    logic [31:0] exp_pa, exp_a2;
    logic exp_fault;
    int exp_reads, t;
    l1d = d1; l2d = d2; lat = lt; n_reads = 0;
    addr1 = 'x; addr2 = 'x; done_after_rv = 1'b0;
    exp_reads = 1; exp_pa = '0; exp_a2 = {d1[31:10], va[19:12], 2'b00};
    case (d1[1:0])
      2'b00: exp_fault = 1'b1;
      2'b01: begin
        exp_reads = 2;
        exp_fault = (d2[1:0] < 2);
        if (!exp_fault) exp_pa = {d2[31:12], va[11:0]};
      end
      default: begin exp_fault = 1'b0; exp_pa = {d1[31:20], va[19:0]}; end
    endcase
    @(negedge clk);
    req_valid = 1'b1; req_va = va; req_ttb = ttb;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!done && t < 40) begin @(negedge clk); t++; end
    chk("R8 done seen", {31'b0, done}, 32'd1);
    chk("R2 l1 address", addr1, {ttb[31:14], va[31:20], 2'b00});
    chk(d1[1:0] == 2'b00 ? "R6 read count" : "R3 read count", n_reads, exp_reads);
    if (exp_reads == 2) chk("R4 l2 address", addr2, exp_a2);
    if (d1[1:0] == 2'b00)      chk("R6 fault", {31'b0, fault}, 32'd1);
    else if (d1[1:0] != 2'b01) begin
      chk("R3 section fault", {31'b0, fault}, 32'd0);
      chk("R3 section pa", pa, exp_pa);
    end else if (exp_fault)    chk("R7 l2 fault", {31'b0, fault}, 32'd1);
    else begin
      chk("R5 page fault", {31'b0, fault}, 32'd0);
      chk("R5 page pa", pa, exp_pa);
    end
    @(negedge clk);
    chk("R8 done on cycle after response", {31'b0, done_after_rv}, 32'd1);
    chk("R8 done one cycle", {31'b0, done}, 32'd0);
    chk("R8 ready after walk", {31'b0, req_ready}, 32'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 3000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready at reset", {31'b0, req_ready}, 32'd1);
    chk("R1 done at reset", {31'b0, done}, 32'd0);
    chk("R1 rd at reset", {31'b0, mem_rd}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, req_ready}, 32'd1);
    for (int t1 = 0; t1 < 4; t1++)
      for (int t2 = 0; t2 < 4; t2++)
        for (int k = 0; k < 6; k++) begin
          logic [31:0] va, ttb, d1, d2;
          va  = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : 32'h9E37_79B9 * (k + 4 * t1 + 16 * t2);
          ttb = 32'hA5A5_C3F0 ^ (32'h0001_3579 * k);
          d1  = ((32'h8765_4321 * (k + 3)) ^ (k == 1 ? 32'hFFFF_FFFF : 32'h0)) & ~32'h3 | t1;
          d2  = ((32'h2468_ACE1 * (k + 7 + t2)) ^ (k == 1 ? 32'hFFFF_FFFF : 32'h0)) & ~32'h3 | t2;
          walk(va, ttb, d1, d2, k % 3);
        end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule